// File: doc/BRIEF.md
# DMA Controller Register Front End

This block is the programming interface of a four-channel DMA controller. A host reaches it through a byte-wide synchronous I/O bus. Each channel keeps a 16-bit base address, a 16-bit base count, a current address, a current transfer count and an 8-bit page byte. The 16-bit registers are loaded and read one byte at a time. A byte-pointer flip-flop shared by all channels picks the low or the high half. A control space holds a status byte, a four-bit channel mask and the clear commands.

A parameter sets the controller to byte or word transfers. In word mode the bus address is shifted right by one before it is decoded, so the ports are spaced two apart. The current address is also held as the base address doubled. Reads scale it back down. A separate page select routes an access to the page bytes, which are decoded from the low three address bits. Two hook inputs let a transfer engine advance a channel's current count and flag terminal counts. Arbitration and the transfer engine itself are not part of the block.

Top module: `dma_regif`

## Requirements
- R1: The port index is io_addr[3:0] in byte mode (WIDE=0) and io_addr[4:1] in word mode (WIDE=1). When page_cs is low, an index of 0 to 7 selects channel index>>1, and index bit 0 picks the address register (0) or the count register (1). An index of 8 to 15 selects the control space.
- R2: Every channel-register read or write flips the byte pointer once. Pointer 0 reaches bits 7:0 and pointer 1 reaches bits 15:8. A write to control index 0xC clears the pointer. Control-space and page accesses leave the pointer alone.
- R3: A low-byte write replaces bits 7:0 of the selected base register and keeps bits 15:8. A high-byte write replaces bits 15:8 and keeps bits 7:0.
- R4: A high-byte write to either register of a channel sets that channel's current address to its base address shifted left by SHIFT (1 in word mode, else 0) and clears its current count to 0.
- R5: An address-register read returns byte ptr of ((current address + current count) >> SHIFT).
- R6: A count-register read returns byte ptr of (((base count << SHIFT) - current count) >> SHIFT), computed modulo 2^(16+SHIFT).
- R7: A read of control index 8 returns {dreq[3:0], sticky[3:0]}. The sticky nibble collects tc_set pulses, and the edge of that read clears it. A tc_set pulse in the same cycle is kept.
- R8: Control index 0xF reads as {4'h0, mask}. A write to 0xA sets (data bit 2 = 1) or clears the mask bit of channel data[1:0]. A write to 0xE clears the mask. A write to 0xF loads data[3:0] into it. Reads of any other control index return 0.
- R9: With page_cs high, offsets 1, 2, 3 and 7 of io_addr[2:0] reach the page bytes of channels 2, 3, 1 and 0. Writes to other offsets change nothing, and reads of them return 0.
- R10: Reset, and a write to control index 0xD, clear the byte pointer and the status nibble and set all four mask bits. Reset also clears every base, current and page register.
- R11: A cycle with adv_valid high and no channel write adds 1 << SHIFT to the current count of channel adv_chan. A channel write wins over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, acts as a master clear |
| io_addr | input | 4+WIDE | Bus address |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, takes effect at the clock edge |
| io_rd | input | 1 | Read strobe; its side effects land at the clock edge |
| page_cs | input | 1 | Selects the page-byte space instead of the controller space |
| dreq | input | 4 | Live request levels reported in the upper status nibble |
| tc_set | input | 4 | Terminal-count pulses that set the sticky status bits |
| adv_valid | input | 1 | Advance request from the transfer engine |
| adv_chan | input | 2 | Channel whose current count advances |
| io_rdata | output | 8 | Combinational read data for the presented address |

## Verification
The assertions check on every cycle that each channel access flips the byte pointer and that a master clear leaves the mask full and the pointer at zero. They also check that a status read with no new terminal count empties the sticky nibble, and that a low-byte write keeps the upper half. A high-byte write must reload the current state from the base, and an invalid page write must leave every page byte unchanged. The read-back arithmetic can only be shown by the bench's scenarios: address plus count, the scaled count minus the current count with its wraparound, and the halving of values in word mode. The same holds for the odd page-offset map, the mask commands and the way the shared pointer runs across different channels.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;

    localparam int NCH    = 4;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 16;
    localparam int IDX_W  = 4;
    localparam int CH_W   = $clog2(NCH);

    typedef enum logic [IDX_W-1:0] {
        CI_STATUS   = 4'h8,
        CI_MASK_ONE = 4'hA,
        CI_CLR_PTR  = 4'hC,
        CI_MCLR     = 4'hD,
        CI_MASK_CLR = 4'hE,
        CI_MASK_ALL = 4'hF
    } ctl_idx_e;

    typedef struct packed {
        logic             is_ctl;
        logic [CH_W-1:0]  chan;
        logic             is_cnt;
        logic [IDX_W-1:0] idx;
    } port_dec_t;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] chan;
    } page_hit_t;

    function automatic port_dec_t decode_index(input logic [IDX_W-1:0] idx);
        port_dec_t d;
        d.idx    = idx;
        d.is_ctl = idx[IDX_W-1];
        d.chan   = idx[CH_W:1];
        d.is_cnt = idx[0];
        return d;
    endfunction

    function automatic page_hit_t page_lookup(input logic [2:0] off);
        page_hit_t h;
        h.valid = 1'b1;
        unique case (off)
            3'd1:    h.chan = 2'd2;
            3'd2:    h.chan = 2'd3;
            3'd3:    h.chan = 2'd1;
            3'd7:    h.chan = 2'd0;
            default: begin h.valid = 1'b0; h.chan = 2'd0; end
        endcase
        return h;
    endfunction

    function automatic logic [REG_W-1:0] merge_byte(input logic [REG_W-1:0] old,
                                                    input logic [BYTE_W-1:0] b,
                                                    input logic hi);
        return hi ? {b, old[BYTE_W-1:0]} : {old[REG_W-1:BYTE_W], b};
    endfunction

endpackage

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              chan_acc,
    input  logic [NCH-1:0]    dreq,
    input  logic [NCH-1:0]    tc_set,
    output logic              ptr,
    output logic [BYTE_W-1:0] ctl_rdata
);
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] sticky_q;
    logic           mclr, clr_ptr, stat_rd;

    assign mclr    = ctl_wr && (idx == CI_MCLR);
    assign clr_ptr = ctl_wr && (idx == CI_CLR_PTR);
    assign stat_rd = ctl_rd && (idx == CI_STATUS);

    always_ff @(posedge clk) begin
        if (rst || mclr || clr_ptr) ptr <= 1'b0;
        else if (chan_acc)          ptr <= ~ptr;
    end

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            mask_q <= '1;
        end else if (ctl_wr) begin
            unique case (idx)
                CI_MASK_ONE: mask_q[wdata[CH_W-1:0]] <= wdata[2];
                CI_MASK_CLR: mask_q <= '0;
                CI_MASK_ALL: mask_q <= wdata[NCH-1:0];
                default:     mask_q <= mask_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || mclr) sticky_q <= '0;
        else             sticky_q <= (stat_rd ? '0 : sticky_q) | tc_set;
    end

    always_comb begin
        unique case (idx)
            CI_STATUS:   ctl_rdata = {dreq, sticky_q};
            CI_MASK_ALL: ctl_rdata = {{(BYTE_W-NCH){1'b0}}, mask_q};
            default:     ctl_rdata = '0;
        endcase
    end

    // R2
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        chan_acc |=> ptr != $past(ptr));

    // R10
    mclr_state_chk: assert property (@(posedge clk) disable iff (rst)
        mclr |=> (mask_q == '1) && !ptr && (sticky_q == '0));

    // R7
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && tc_set == '0) |=> sticky_q == '0);
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_regif_pkg::*;
#(
    parameter int SHIFT = 0,
    localparam int CUR_W = REG_W + SHIFT
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic              is_cnt,
    input  logic              hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              adv,
    output logic [REG_W-1:0]  base_addr,
    output logic [REG_W-1:0]  base_cnt,
    output logic [CUR_W-1:0]  cur_addr,
    output logic [CUR_W-1:0]  cur_cnt
);
    localparam logic [CUR_W-1:0] STEP = CUR_W'(1) << SHIFT;

    logic [REG_W-1:0] next_addr;
    assign next_addr = is_cnt ? base_addr : merge_byte(base_addr, wdata, hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else if (wr_sel) begin
            if (is_cnt) base_cnt  <= merge_byte(base_cnt, wdata, hi);
            else        base_addr <= next_addr;
            if (hi) begin
                cur_addr <= CUR_W'(next_addr) << SHIFT;
                cur_cnt  <= '0;
            end
        end else if (adv) begin
            cur_cnt <= cur_cnt + STEP;
        end
    end

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && hi) |=> (cur_cnt == '0) && (cur_addr == (CUR_W'(base_addr) << SHIFT)));

    // R3
    low_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && !hi && !is_cnt) |=> $stable(base_addr[REG_W-1:BYTE_W]));
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
    import dma_regif_pkg::*;
#(
    parameter int SHIFT = 0,
    localparam int CUR_W = REG_W + SHIFT
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_wr,
    input  logic [CH_W-1:0]   chan,
    input  logic              is_cnt,
    input  logic              ptr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              adv_valid,
    input  logic [CH_W-1:0]   adv_chan,
    output logic [BYTE_W-1:0] chan_rdata
);
    logic [NCH-1:0][REG_W-1:0] base_addr, base_cnt;
    logic [NCH-1:0][CUR_W-1:0] cur_addr, cur_cnt;

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        dma_chan_slot #(.SHIFT(SHIFT)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (chan_wr && (chan == CH_W'(g))),
            .is_cnt   (is_cnt),
            .hi       (ptr),
            .wdata    (wdata),
            .adv      (adv_valid && (adv_chan == CH_W'(g))),
            .base_addr(base_addr[g]),
            .base_cnt (base_cnt[g]),
            .cur_addr (cur_addr[g]),
            .cur_cnt  (cur_cnt[g])
        );
    end

    logic [CUR_W-1:0] raw, scaled;
    always_comb begin
        if (is_cnt) raw = (CUR_W'(base_cnt[chan]) << SHIFT) - cur_cnt[chan];
        else        raw = cur_addr[chan] + cur_cnt[chan];
        scaled     = raw >> SHIFT;
        chan_rdata = ptr ? scaled[REG_W-1:BYTE_W] : scaled[BYTE_W-1:0];
    end
endmodule

// File: rtl/dma_page_bank.sv
module dma_page_bank
    import dma_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              page_wr,
    input  logic [2:0]        off,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] page_rdata
);
    logic [NCH-1:0][BYTE_W-1:0] page_q;
    page_hit_t hit;

    assign hit = page_lookup(off);

    always_ff @(posedge clk) begin
        if (rst)                    page_q <= '0;
        else if (page_wr && hit.valid) page_q[hit.chan] <= wdata;
    end

    assign page_rdata = hit.valid ? page_q[hit.chan] : '0;

    // R9
    page_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (page_wr && !hit.valid) |=> $stable(page_q));
endmodule

// File: rtl/dma_regif.sv
module dma_regif
    import dma_regif_pkg::*;
#(
    parameter bit WIDE = 1'b0,
    localparam int SHIFT  = WIDE ? 1 : 0,
    localparam int ADDR_W = IDX_W + SHIFT
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              page_cs,
    input  logic [NCH-1:0]    dreq,
    input  logic [NCH-1:0]    tc_set,
    input  logic              adv_valid,
    input  logic [CH_W-1:0]   adv_chan,
    output logic [BYTE_W-1:0] io_rdata
);
    port_dec_t        dec;
    logic             chan_space, ctl_space, ptr;
    logic [BYTE_W-1:0] chan_rdata, ctl_rdata, page_rdata;

    assign dec        = decode_index(io_addr[ADDR_W-1:SHIFT]);
    assign chan_space = !page_cs && !dec.is_ctl;
    assign ctl_space  = !page_cs && dec.is_ctl;

    dma_ctl_regs u_ctl (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (io_wr && ctl_space),
        .ctl_rd   (io_rd && !io_wr && ctl_space),
        .idx      (dec.idx),
        .wdata    (io_wdata),
        .chan_acc ((io_wr || io_rd) && chan_space),
        .dreq     (dreq),
        .tc_set   (tc_set),
        .ptr      (ptr),
        .ctl_rdata(ctl_rdata)
    );

    dma_chan_bank #(.SHIFT(SHIFT)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .chan_wr   (io_wr && chan_space),
        .chan      (dec.chan),
        .is_cnt    (dec.is_cnt),
        .ptr       (ptr),
        .wdata     (io_wdata),
        .adv_valid (adv_valid),
        .adv_chan  (adv_chan),
        .chan_rdata(chan_rdata)
    );

    dma_page_bank u_page (
        .clk       (clk),
        .rst       (rst),
        .page_wr   (io_wr && page_cs),
        .off       (io_addr[2:0]),
        .wdata     (io_wdata),
        .page_rdata(page_rdata)
    );

    always_comb begin
        if (page_cs)         io_rdata = page_rdata;
        else if (dec.is_ctl) io_rdata = ctl_rdata;
        else                 io_rdata = chan_rdata;
    end
endmodule

// File: tb/tb_dma_regif.sv
module tb_dma_regif;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0, wdata = '0;
    logic       page_cs = 1'b0;
    logic       n_wr = 0, n_rd = 0, w_wr = 0, w_rd = 0, n_adv = 0, w_adv = 0;
    logic [1:0] adv_chan = '0;
    logic [3:0] dreq = '0, tc_set = '0;
    logic [7:0] rd_n, rd_w;
    int total = 0, bad = 0, cycles = 0;

    always #2 clk = ~clk;

    dma_regif dut (
        .clk(clk), .rst(rst), .io_addr(addr[3:0]), .io_wdata(wdata),
        .io_wr(n_wr), .io_rd(n_rd), .page_cs(page_cs), .dreq(dreq),
        .tc_set(tc_set), .adv_valid(n_adv), .adv_chan(adv_chan), .io_rdata(rd_n));

    dma_regif #(.WIDE(1'b1)) dut_w (
        .clk(clk), .rst(rst), .io_addr(addr[4:0]), .io_wdata(wdata),
        .io_wr(w_wr), .io_rd(w_rd), .page_cs(page_cs), .dreq(dreq),
        .tc_set(tc_set), .adv_valid(w_adv), .adv_chan(adv_chan), .io_rdata(rd_w));

    localparam int OP_W = 0, OP_R = 1, OP_P = 2, OP_Q = 3;
    localparam int NV = 34;
    // {op, address, data, expected}
    localparam logic [25:0] VEC [0:NV-1] = '{
        {2'd0, 8'h02, 8'h34, 8'h00},  // R3 ch1 addr low
        {2'd0, 8'h02, 8'h12, 8'h00},  // R3 ch1 addr high
        {2'd1, 8'h02, 8'h00, 8'h34},  // R5
        {2'd1, 8'h02, 8'h00, 8'h12},  // R5
        {2'd0, 8'h03, 8'hFF, 8'h00},  // R1 ch1 count
        {2'd0, 8'h03, 8'h00, 8'h00},
        {2'd1, 8'h03, 8'h00, 8'hFF},  // R6
        {2'd1, 8'h03, 8'h00, 8'h00},
        {2'd0, 8'h0C, 8'h00, 8'h00},  // R2 clear pointer
        {2'd0, 8'h04, 8'hAA, 8'h00},
        {2'd0, 8'h0C, 8'h00, 8'h00},  // R2 clear pointer again
        {2'd0, 8'h04, 8'hBB, 8'h00},
        {2'd0, 8'h04, 8'hCC, 8'h00},
        {2'd1, 8'h04, 8'h00, 8'hBB},  // R2
        {2'd1, 8'h04, 8'h00, 8'hCC},
        {2'd2, 8'h01, 8'h55, 8'h00},  // R9 offset 1 -> ch2
        {2'd3, 8'h01, 8'h00, 8'h55},
        {2'd2, 8'h04, 8'h99, 8'h00},  // R9 invalid
        {2'd3, 8'h04, 8'h00, 8'h00},
        {2'd2, 8'h07, 8'h66, 8'h00},
        {2'd3, 8'h07, 8'h00, 8'h66},
        {2'd3, 8'h02, 8'h00, 8'h00},
        {2'd1, 8'h0F, 8'h00, 8'h0F},  // R8
        {2'd0, 8'h0A, 8'h01, 8'h00},
        {2'd1, 8'h0F, 8'h00, 8'h0D},
        {2'd0, 8'h0E, 8'h00, 8'h00},
        {2'd1, 8'h0F, 8'h00, 8'h00},
        {2'd0, 8'h0F, 8'h05, 8'h00},
        {2'd1, 8'h0F, 8'h00, 8'h05},
        {2'd0, 8'h0A, 8'h05, 8'h00},
        {2'd1, 8'h0F, 8'h00, 8'h07},
        {2'd1, 8'h0B, 8'h00, 8'h00},  // R8 other index
        {2'd0, 8'h0D, 8'h00, 8'h00},  // R10 master clear
        {2'd1, 8'h0F, 8'h00, 8'h0F}
    };

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic bus_op(input bit wide, input int op, input logic [7:0] a,
                          input logic [7:0] d, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; wdata = d;
        page_cs = (op == OP_P) || (op == OP_Q);
        if (wide) begin w_wr = (op == OP_W) || (op == OP_P); w_rd = (op == OP_R) || (op == OP_Q); end
        else      begin n_wr = (op == OP_W) || (op == OP_P); n_rd = (op == OP_R) || (op == OP_Q); end
        #1;
        if (op == OP_R || op == OP_Q) check(wide ? rd_w : rd_n, e, tag);
        @(posedge clk); #1;
        n_wr = 0; n_rd = 0; w_wr = 0; w_rd = 0; page_cs = 0;
    endtask

    task automatic advance(input bit wide, input logic [1:0] ch);
        @(negedge clk);
        adv_chan = ch;
        if (wide) w_adv = 1; else n_adv = 1;
        @(posedge clk); #1;
        n_adv = 0; w_adv = 0;
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R10 reset state
        bus_op(0, OP_R, 8'h0F, 0, 8'h0F, "R10 mask after reset");
        bus_op(0, OP_R, 8'h08, 0, 8'h00, "R10 status after reset");
        bus_op(0, OP_R, 8'h00, 0, 8'h00, "R10 ch0 addr low");
        bus_op(0, OP_R, 8'h00, 0, 8'h00, "R10 ch0 addr high");

        for (int i = 0; i < NV; i++)
            bus_op(0, int'(VEC[i][25:24]), VEC[i][23:16], VEC[i][15:8], VEC[i][7:0],
                   $sformatf("R1/R2/R3/R5/R6/R8/R9/R10 vector %0d", i));

        // R11 advance then R5/R6 readback
        advance(0, 2'd1); advance(0, 2'd1);
        bus_op(0, OP_R, 8'h02, 0, 8'h36, "R11 R5 addr+count low");
        bus_op(0, OP_R, 8'h02, 0, 8'h12, "R11 R5 addr+count high");
        bus_op(0, OP_R, 8'h03, 0, 8'hFD, "R11 R6 remaining low");
        bus_op(0, OP_R, 8'h03, 0, 8'h00, "R11 R6 remaining high");
        // R6 wraparound on channel 3
        bus_op(0, OP_R, 8'h07, 0, 8'h00, "R6 ch3 zero low");
        bus_op(0, OP_R, 8'h07, 0, 8'h00, "R6 ch3 zero high");
        advance(0, 2'd3);
        bus_op(0, OP_R, 8'h07, 0, 8'hFF, "R6 wrap low");
        bus_op(0, OP_R, 8'h07, 0, 8'hFF, "R6 wrap high");
        // R4 high write reloads current state
        bus_op(0, OP_W, 8'h02, 8'h00, 0, "R4 low");
        bus_op(0, OP_W, 8'h02, 8'h20, 0, "R4 high");
        bus_op(0, OP_R, 8'h02, 0, 8'h00, "R4 addr low");
        bus_op(0, OP_R, 8'h02, 0, 8'h20, "R4 addr high");
        bus_op(0, OP_R, 8'h03, 0, 8'hFF, "R4 count cleared low");
        bus_op(0, OP_R, 8'h03, 0, 8'h00, "R4 count cleared high");

        // R7 status
        dreq = 4'hA;
        @(negedge clk); tc_set = 4'h5; @(posedge clk); #1 tc_set = 4'h0;
        bus_op(0, OP_R, 8'h08, 0, 8'hA5, "R7 status with sticky");
        bus_op(0, OP_R, 8'h08, 0, 8'hA0, "R7 sticky cleared");
        dreq = 4'h0;

        // R1 word mode decode and scaling
        bus_op(1, OP_W, 8'h04, 8'h00, 0, "R1 wide low");
        bus_op(1, OP_W, 8'h05, 8'h10, 0, "R1 wide high, bit0 ignored");
        bus_op(1, OP_R, 8'h04, 0, 8'h00, "R1 R5 wide addr low");
        bus_op(1, OP_R, 8'h04, 0, 8'h10, "R1 R5 wide addr high");
        advance(1, 2'd1);
        bus_op(1, OP_R, 8'h04, 0, 8'h01, "R11 wide addr low");
        bus_op(1, OP_R, 8'h04, 0, 8'h10, "R11 wide addr high");
        bus_op(1, OP_R, 8'h06, 0, 8'hFF, "R6 wide count low");
        bus_op(1, OP_R, 8'h06, 0, 8'hFF, "R6 wide count high");
        bus_op(1, OP_R, 8'h1E, 0, 8'h0F, "R1 R8 wide mask index");
        bus_op(1, OP_P, 8'h01, 8'h77, 0, "R9 wide page");
        bus_op(1, OP_Q, 8'h01, 0, 8'h77, "R9 wide page read");

        // R10 reset clears registers
        @(negedge clk); rst = 1; @(posedge clk); #1 rst = 0;
        bus_op(0, OP_Q, 8'h01, 0, 8'h00, "R10 page cleared");
        bus_op(0, OP_R, 8'h02, 0, 8'h00, "R10 pointer and addr cleared");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule